// File: doc/BRIEF.md
# Multi-Axis Masked Host Interrupt Controller

This block gathers event flags from every axis of a multi-axis motion controller and drives a single active-high interrupt line toward the host. Each axis keeps a status word. Bits 0 to 7 are sticky event flags, set by single-cycle event pulses. Bit 11 follows a live command-error level from the host-communication logic. Each axis also holds a mask that decides which of these bits may raise the interrupt.

The host talks to the block through a one-cycle command strobe that carries an opcode and a 16-bit argument. Read commands answer one cycle later with a response strobe. The host can set a mask for the current axis and read the status of the interrupting axis. It can jump to the interrupting axis, or acknowledge the interrupt with an active-low clearing mask. The axis reported as interrupting is the lowest-numbered axis that has an enabled flag set. After an acknowledge, the line drops for a short gap. It then rises again if any enabled flag is still pending, so each new interrupt gives the host a fresh rising edge.

Top module: `irq_host_ctrl`

## Requirements
- R1: A high bit on an axis's event input sets the matching status flag (bits 0 to 7). The flag stays set until it is cleared and is latched whatever the mask holds.
- R2: `irq_o` is high one cycle after at least one axis has a flag set, or its command-error level high, while the matching mask bit (0 to 7, or 11) is 1. With no such bit, `irq_o` stays low.
- R3: When an event sets a flag in the same cycle that a clear command removes it, the set wins.
- R4: The interrupting axis is the lowest-numbered axis with a pending enabled bit. A get-interrupt reply holds that axis's flags in bits 7:0, its command-error level in bit 11 and its axis number in bits 13:12.
- R5: Select-axis sets the current axis to arg[1:0]. Get-interrupt and reset-interrupt leave the current axis unchanged.
- R6: Switch-to-interrupting-axis sets the current axis to the interrupting axis. It is ignored when nothing is pending.
- R7: Reset-interrupt clears each bit of the interrupting axis's flags 7:0 whose arg bit is 0, so several flags can go at once. Bit 11 is not affected.
- R8: After a reset-interrupt, `irq_o` is low in the two cycles that follow the command. It rises again in the next cycle if any enabled bit is still pending.
- R9: Clear-status applies the same active-low arg[7:0] mask to flags 7:0 of the current axis only.
- R10: After reset, the interrupt line, the current axis, all flags, all masks and the response strobe are 0.
- R11: Opcodes are 0 no-op, 1 select axis, 2 set mask (current axis), 3 get interrupt, 4 switch to interrupting axis, 5 reset interrupt, 6 clear status, 7 get status. Get status returns the current axis's word with its number in bits 13:12. `rsp_valid_o` pulses one cycle after opcodes 3 and 7 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_AXES*8 | Event pulses, 8 bits per axis, axis a at [a*8 +: 8] |
| cerr_i | input | N_AXES | Command-error level per axis (status bit 11) |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode |
| cmd_arg_i | input | STAT_W | Command argument |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | STAT_W | Response status word |
| cur_axis_o | output | AW | Current axis number |
| irq_o | output | 1 | Host interrupt line, active high |

## Verification
Flags, masks and the current axis change at the clock edge that samples the event or command. Replies and the interrupt line each pass through one more register, so they are due one edge later. After a reset-interrupt, the line stays low through the command edge and the edge after it, and can rise again at the third edge. The bench drives every input and samples every output on falling edges. It counts whole cycles from the edge that takes a stimulus, so each check lands in the exact cycle in which the result is due.

// File: rtl/irq_host_ctrl_pkg.sv
package irq_host_ctrl_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_SEL  = 3'd1,
    OP_MASK = 3'd2,
    OP_GETI = 3'd3,
    OP_SWI  = 3'd4,
    OP_RSTI = 3'd5,
    OP_CLRS = 3'd6,
    OP_GETS = 3'd7
  } op_e;

  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned CERR_BIT = 11;
  localparam int unsigned AXIS_LSB = 12;
endpackage

// File: rtl/irq_axis_stat.sv
module irq_axis_stat
  import irq_host_ctrl_pkg::*;
#(
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic              cerr_i,
  input  logic              clr_en_i,
  input  logic [FLAG_W-1:0] keep_i,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              pend_o
);
  logic [FLAG_W-1:0] flags_q;
  logic [STAT_W-1:0] mask_q;
  logic [FLAG_W-1:0] keep;

  assign keep = clr_en_i ? keep_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      // set beats clear
      flags_q <= (flags_q & keep) | evt_i;
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[FLAG_W-1:0] = flags_q;
    stat_o[CERR_BIT] = cerr_i;
  end

  assign pend_o = (|(flags_q & mask_q[FLAG_W-1:0])) | (cerr_i & mask_q[CERR_BIT]);

  // R1 R3
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  // R9 R7
  no_clear_without_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [AW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = AW'(i);
    end
  end

  assign any_o = |req_i;

  // R4
  prio_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> req_i[idx_o]);

  // R4
  prio_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
endmodule

// File: rtl/irq_host_ctrl.sv
module irq_host_ctrl
  import irq_host_ctrl_pkg::*;
#(
  parameter int unsigned N_AXES = 4,
  parameter int unsigned STAT_W = 16,
  localparam int unsigned AW    = (N_AXES > 1) ? $clog2(N_AXES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_AXES*FLAG_W-1:0]   evt_i,
  input  logic [N_AXES-1:0]          cerr_i,
  input  logic                       cmd_valid_i,
  input  logic [2:0]                 cmd_op_i,
  input  logic [STAT_W-1:0]          cmd_arg_i,
  output logic                       rsp_valid_o,
  output logic [STAT_W-1:0]          rsp_data_o,
  output logic [AW-1:0]              cur_axis_o,
  output logic                       irq_o
);
  op_e               op;
  logic              is_sel, is_mask, is_geti, is_swi, is_rsti, is_clrs, is_gets;
  logic [N_AXES-1:0] pend;
  logic [STAT_W-1:0] stat_w [N_AXES];
  logic              any_pend;
  logic [AW-1:0]     irq_axis;
  logic [AW-1:0]     cur_q;
  logic              hold_q, irq_q, rsp_valid_q;
  logic [STAT_W-1:0] rsp_data_q;

  assign op      = op_e'(cmd_op_i);
  assign is_sel  = cmd_valid_i && (op == OP_SEL);
  assign is_mask = cmd_valid_i && (op == OP_MASK);
  assign is_geti = cmd_valid_i && (op == OP_GETI);
  assign is_swi  = cmd_valid_i && (op == OP_SWI);
  assign is_rsti = cmd_valid_i && (op == OP_RSTI);
  assign is_clrs = cmd_valid_i && (op == OP_CLRS);
  assign is_gets = cmd_valid_i && (op == OP_GETS);

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    logic clr_en;
    assign clr_en = (is_rsti && any_pend && (irq_axis == AW'(a)))
                 || (is_clrs && (cur_q == AW'(a)));
    irq_axis_stat #(.STAT_W(STAT_W)) u_stat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[a*FLAG_W +: FLAG_W]),
      .cerr_i    (cerr_i[a]),
      .clr_en_i  (clr_en),
      .keep_i    (cmd_arg_i[FLAG_W-1:0]),
      .mask_we_i (is_mask && (cur_q == AW'(a))),
      .mask_i    (cmd_arg_i),
      .stat_o    (stat_w[a]),
      .pend_o    (pend[a])
    );
  end

  irq_prio #(.N(N_AXES), .AW(AW)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (pend),
    .any_o  (any_pend),
    .idx_o  (irq_axis)
  );

  function automatic logic [STAT_W-1:0] tag_axis(logic [STAT_W-1:0] w, logic [AW-1:0] ax);
    logic [STAT_W-1:0] r;
    r = w;
    r[AXIS_LSB +: AW] = ax;
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q       <= '0;
      hold_q      <= 1'b0;
      irq_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (is_sel)                cur_q <= cmd_arg_i[AW-1:0];
      else if (is_swi && any_pend) cur_q <= irq_axis;
      hold_q      <= is_rsti;
      // gap after acknowledge so the host sees a fresh edge
      irq_q       <= any_pend && !is_rsti && !hold_q;
      rsp_valid_q <= is_geti || is_gets;
      if (is_geti)      rsp_data_q <= tag_axis(stat_w[irq_axis], irq_axis);
      else if (is_gets) rsp_data_q <= tag_axis(stat_w[cur_q], cur_q);
    end
  end

  assign cur_axis_o  = cur_q;
  assign irq_o       = irq_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  // R8
  rsti_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rsti |=> !irq_o ##1 !irq_o);

  // R5
  cur_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_geti || is_rsti) |=> $stable(cur_axis_o));

  // R11
  rsp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(is_geti || is_gets));

  // R2
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(any_pend));
endmodule

// File: tb/irq_host_ctrl_bench.sv
module irq_host_ctrl_bench;
  localparam int N  = 4;
  localparam int SW = 16;
  localparam logic [2:0] C_SEL = 3'd1, C_MASK = 3'd2, C_GETI = 3'd3, C_SWI = 3'd4,
                         C_RSTI = 3'd5, C_CLRS = 3'd6, C_GETS = 3'd7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*8-1:0]  evt = '0;
  logic [N-1:0]    cerr = '0;
  logic            cmd_valid = 1'b0;
  logic [2:0]      cmd_op = '0;
  logic [SW-1:0]   cmd_arg = '0;
  logic            rsp_valid;
  logic [SW-1:0]   rsp_data;
  logic [1:0]      cur_axis;
  logic            irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_host_ctrl #(.N_AXES(N), .STAT_W(SW)) u_irq_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cerr_i(cerr),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_arg_i(cmd_arg),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .cur_axis_o(cur_axis), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cmd(logic [2:0] op, logic [SW-1:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_arg = '0;
  endtask

  task automatic pulse(logic [N*8-1:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    chk("R10 irq", irq, 0);
    chk("R10 cur", cur_axis, 0);
    chk("R10 rsp_valid", rsp_valid, 0);
    do_cmd(C_GETS, 0);
    chk("R10 flags", rsp_data, 16'h0000);
  endtask

  task automatic t_mask_off;
    pulse(32'h0000_0100);            // axis1 bit0, masks still zero
    wait_n(2);
    chk("R2 masked", irq, 0);
    do_cmd(C_SEL, 1);
    chk("R11 no rsp", rsp_valid, 0);
    chk("R5 sel", cur_axis, 1);
    do_cmd(C_GETS, 0);
    chk("R11 rsp", rsp_valid, 1);
    chk("R1 latched", rsp_data, 16'h1001);
    do_cmd(C_CLRS, 16'h00FE);
    do_cmd(C_GETS, 0);
    chk("R9 clear", rsp_data, 16'h1000);
  endtask

  task automatic t_set_masks;
    for (int a = 0; a < N; a++) begin
      do_cmd(C_SEL, SW'(a));
      do_cmd(C_MASK, 16'h08FF);
    end
    do_cmd(C_SEL, 0);
  endtask

  task automatic t_priority;
    pulse(32'h0208_0000);            // axis2 bit3, axis3 bit1 together
    wait_n(1);
    chk("R2 raise", irq, 1);
    do_cmd(C_GETI, 0);
    chk("R4 lowest", rsp_data, 16'h2008);
    chk("R5 geti keeps", cur_axis, 0);
    do_cmd(C_RSTI, 16'h00F7);
    chk("R5 rsti keeps", cur_axis, 0);
    chk("R8 gap0", irq, 0);
    wait_n(1);
    chk("R8 gap1", irq, 0);
    wait_n(1);
    chk("R8 reassert", irq, 1);
    do_cmd(C_GETI, 0);
    chk("R4 next", rsp_data, 16'h3002);
    do_cmd(C_SWI, 0);
    chk("R6 switch", cur_axis, 3);
    do_cmd(C_RSTI, 16'h00FD);
    wait_n(3);
    chk("R8 stays low", irq, 0);
  endtask

  task automatic t_one_at_a_time;
    pulse(32'h0000_3000);            // axis1 bits 4,5
    wait_n(1);
    do_cmd(C_GETI, 0);
    chk("R4 both", rsp_data, 16'h1030);
    do_cmd(C_RSTI, 16'h00EF);
    wait_n(2);
    chk("R8 pending reassert", irq, 1);
    do_cmd(C_GETI, 0);
    chk("R7 single clear", rsp_data, 16'h1020);
    do_cmd(C_RSTI, 16'h00DF);
    wait_n(3);
    chk("R7 all clear irq", irq, 0);
    chk("R5 cur kept", cur_axis, 3);
  endtask

  task automatic t_multi_clear;
    pulse(32'h0000_0081);
    wait_n(1);
    chk("R2 axis0", irq, 1);
    do_cmd(C_GETI, 0);
    chk("R4 axis0", rsp_data, 16'h0081);
    do_cmd(C_RSTI, 16'h007E);
    wait_n(3);
    chk("R7 multi irq", irq, 0);
    do_cmd(C_SEL, 0);
    do_cmd(C_GETS, 0);
    chk("R7 multi flags", rsp_data, 16'h0000);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    evt = 32'h0000_0004;
    cmd_valid = 1'b1; cmd_op = C_CLRS; cmd_arg = 16'h0000;
    @(negedge clk);
    evt = '0; cmd_valid = 1'b0; cmd_op = '0;
    do_cmd(C_GETS, 0);
    chk("R3 set wins", rsp_data, 16'h0004);
    do_cmd(C_CLRS, 16'h0000);
    do_cmd(C_GETS, 0);
    chk("R9 cleared", rsp_data, 16'h0000);
    wait_n(1);
    chk("R2 drop", irq, 0);
  endtask

  task automatic t_cmd_err;
    @(negedge clk);
    cerr = 4'b0100;
    wait_n(1);
    chk("R2 cerr raise", irq, 1);
    do_cmd(C_GETI, 0);
    chk("R4 cerr word", rsp_data, 16'h2800);
    do_cmd(C_RSTI, 16'h0000);
    wait_n(2);
    chk("R7 bit11 kept", irq, 1);
    @(negedge clk);
    cerr = '0;
    wait_n(1);
    chk("R2 cerr drop", irq, 0);
    do_cmd(C_SEL, 2);
    do_cmd(C_MASK, 16'h00FF);
    @(negedge clk);
    cerr = 4'b0100;
    wait_n(2);
    chk("R2 bit11 masked", irq, 0);
    do_cmd(C_GETS, 0);
    chk("R11 gets cerr", rsp_data, 16'h2800);
    cerr = '0;
    do_cmd(C_SWI, 0);
    chk("R6 swi idle", cur_axis, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset;
    t_mask_off;
    t_set_masks;
    t_priority;
    t_one_at_a_time;
    t_multi_clear;
    t_set_wins;
    t_cmd_err;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule